// File: doc/BRIEF.md
# Window-masked segmented pulse-width modulator

This block turns a 6-bit duty command into a pulse-width modulated drive signal. It does not run a counter at the full resolution. The upper command bits go to a slot counter clocked by the base clock. The lower bits pick one edge out of a set of phase-shifted tap clocks that arrive from outside the block. A switching period lasts 2^CNT_W base-clock cycles, and each base cycle forms one slot. The output goes high when a period begins. It is cleared by the first selected fine edge inside the one slot whose number equals the upper command bits.

The fine edge is selected in two cascaded stages. The first stage narrows four phase clocks to quarter-period pulses by gating each one with the true or the inverted double-rate clock, and two command bits choose one of these pulses. The second stage uses four quarter-duty taps at four times the base rate, and the lowest two command bits choose one of them. A registered window, high only in the matching slot, gates the whole fine path. Tap activity in every other slot therefore never reaches the output. The counter clock and the phase taps must come from one source, so that the set edge and the clearing edge line up.

Top module: `seg_window_dpwm`

## Requirements
- R1: While the active-low reset is low, the output is low, and it goes low at once when reset is asserted. After reset is released, the first rising base-clock edge begins a new period.
- R2: The slot counter advances by one on every rising base-clock edge and wraps from 2^CNT_W-1 to 0. One slot is one base-clock cycle, and one period is 2^CNT_W cycles (4 with defaults).
- R3: The output rises at the edge on which the counter wraps to zero. Within a period it has exactly one high interval, and that interval begins at the period start.
- R4: The duty command is captured only on the period-start edge. A change made at any other time has no effect until the next period.
- R5: The fine path is enabled only during the slot whose index equals command bits [5:4]. Tap edges in earlier slots leave the output high. At the end of each slot numbered below bits [5:4] the output is high, and at the end of the matching slot and of every later slot it is low.
- R6: First-stage tap k (k = 0..3) is phase clock k ANDed with the double-rate clock for even k and with the inverted double-rate clock for odd k. This gives a pulse over quarter k of the base cycle. Command bits [3:2] give k.
- R7: Second-stage tap j (j = 0..3) is high for sixteenth j of each quarter of the base cycle. Command bits [1:0] give j. The clearing edge is the first rising edge of window AND first-stage pick AND second-stage pick.
- R8: The high time equals the command value times T/16, where T is the base-clock period. This is the command over 2^6 of the switching period, so each LSB is one sixty-fourth of the period.
- R9: Command 27 (011011) clears in slot 1, quarter 2 (180 degrees) and sixteenth 3, which is a high time of 27 steps.
- R10: Command 0 sets and clears the output on the same period-start edge, so no high time can be measured in slot 0. Command 63 gives 63 of 64 steps and is low during the last step.
- R11: A fine edge that comes after the clear, or an old-window edge that coincides with a period start, never leaves the output high. Going from command 48 to command 0 gives no high time in the second period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_base_i | input | 1 | Base clock that drives the slot counter |
| rst_n_i | input | 1 | Synchronous active-low reset, which also forces the output low |
| ph_i | input | 4 | Half-duty phase clocks at 0, 90, 180 and 270 degrees of the base clock |
| clk2x_i | input | 1 | Half-duty clock at twice the base rate, aligned to phase 0 |
| qtap_i | input | 4 | Quarter-duty taps at four times the base rate, tap j delayed by j sixteenths of T |
| duty_i | input | 6 | Duty command |
| pwm_o | output | 1 | Modulated drive output |

## Verification
The bench builds the block with its defaults: a 2-bit counter and 4 fine bits, so a period is four base cycles. At these sizes every slot, every first-stage quarter and every second-stage tap can be reached with a handful of commands. The taps are made from a 0.625 ns step grid. The bench samples the output in the middle of each of the 64 steps, which turns each measured high time into an exact step count that can be compared with the command. This also makes the coincident-edge cases reachable: command 0, the full-scale command, and a slot-3 command followed by a slot-0 command.

// File: rtl/dpwm_pkg.sv
// Shared constants for the segmented modulator.
// Assumes exactly four taps per fine stage, so each stage decodes two bits.
package dpwm_pkg;
    localparam int unsigned TAP_N = 4;
    localparam int unsigned STG_W = 2;
    typedef logic [STG_W-1:0] stage_sel_t;
endpackage

// File: rtl/dpwm_slot_timer.sv
// Slot counter, period-start command capture and window register.
// Assumes the counter reset value is all ones, so the first edge after reset starts a period.
module dpwm_slot_timer #(
    parameter int CNT_W  = 2,
    parameter int DUTY_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DUTY_W-1:0] duty_i,
    output logic [CNT_W-1:0]  cnt_o,
    output logic [DUTY_W-1:0] duty_q_o,
    output logic              wrap_o,
    output logic              win_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
    localparam logic [CNT_W-1:0] CNT_ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    logic [CNT_W-1:0]  cnt_nx;
    logic [DUTY_W-1:0] duty_nx;

    // Next count and the command that will govern the next slot.
    always_comb begin
        cnt_nx  = cnt_o + CNT_ONE;
        duty_nx = wrap_o ? duty_i : duty_q_o;
    end

    assign wrap_o = (cnt_o == CNT_MAX);

    // Advance the slot, capture the command at period start, and precompute the window.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_o    <= CNT_MAX;
            duty_q_o <= '0;
            win_o    <= 1'b0;
        end else begin
            cnt_o    <= cnt_nx;
            duty_q_o <= duty_nx;
            win_o    <= (cnt_nx == duty_nx[DUTY_W-1 -: CNT_W]);
        end
    end
endmodule

// File: rtl/dpwm_fine_path.sv
// Two-stage fine edge selection gated by the slot window.
// Assumes the taps are phase aligned with the base clock and that FINE_W is two stages of two bits.
module dpwm_fine_path
    import dpwm_pkg::*;
#(
    parameter int FINE_W = 4
) (
    input  logic [TAP_N-1:0]  ph_i,
    input  logic              clk2x_i,
    input  logic [TAP_N-1:0]  qtap_i,
    input  logic              win_i,
    input  logic [FINE_W-1:0] sel_i,
    output logic              hit_o
);
    logic [TAP_N-1:0] narrow;
    stage_sel_t       sel_a;
    stage_sel_t       sel_b;

    // First stage: each phase clock is cut to its own quarter by the double-rate clock.
    for (genvar k = 0; k < TAP_N; k++) begin : g_narrow
        if (k % 2 == 0) begin : g_even
            assign narrow[k] = ph_i[k] & clk2x_i;
        end else begin : g_odd
            assign narrow[k] = ph_i[k] & ~clk2x_i;
        end
    end

    // Split the fine bits into the two stage selects and gate the chosen pair.
    always_comb begin
        sel_a = sel_i[FINE_W-1 -: STG_W];
        sel_b = sel_i[STG_W-1:0];
        hit_o = win_i & narrow[sel_a] & qtap_i[sel_b];
    end
endmodule

// File: rtl/dpwm_out_latch.sv
// Set/clear output stage made of a set flop and a clear latch; output is their difference.
// Assumes exactly one window per period; repeated clear edges are harmless.
module dpwm_out_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic wrap_i,
    input  logic hit_i,
    output logic pwm_o
);
    logic set_q;
    logic clr_q;

    // Set side: at period start make set differ from clear, which raises the output.
    always_ff @(posedge clk) begin
        if (!rst_n) set_q <= 1'b0;
        else if (wrap_i) set_q <= ~clr_q;
    end

    // Clear side: follows set while the fine hit or reset is present, which drops the output.
    always_latch begin
        if (!rst_n || hit_i) clr_q = set_q;
    end

    assign pwm_o = set_q ^ clr_q;
endmodule

// File: rtl/seg_window_dpwm.sv
// Top level of the window-masked segmented modulator.
// Assumes the counter clock and all taps come from one source; the command splits as CNT_W + FINE_W.
module seg_window_dpwm #(
    parameter int CNT_W  = 2,
    parameter int FINE_W = 4,
    parameter int DUTY_W = 6
) (
    input  logic              clk_base_i,
    input  logic              rst_n_i,
    input  logic [3:0]        ph_i,
    input  logic              clk2x_i,
    input  logic [3:0]        qtap_i,
    input  logic [DUTY_W-1:0] duty_i,
    output logic              pwm_o
);
    if (CNT_W + FINE_W != DUTY_W || FINE_W != 2 * dpwm_pkg::STG_W) begin : g_bad_split
        $error("command split does not match the two-stage fine path");
    end

    logic [CNT_W-1:0]  cnt;
    logic [DUTY_W-1:0] duty_q;
    logic              wrap;
    logic              win;
    logic              hit;

    dpwm_slot_timer #(.CNT_W(CNT_W), .DUTY_W(DUTY_W)) u_timer (
        .clk      (clk_base_i),
        .rst_n    (rst_n_i),
        .duty_i   (duty_i),
        .cnt_o    (cnt),
        .duty_q_o (duty_q),
        .wrap_o   (wrap),
        .win_o    (win)
    );

    dpwm_fine_path #(.FINE_W(FINE_W)) u_fine (
        .ph_i    (ph_i),
        .clk2x_i (clk2x_i),
        .qtap_i  (qtap_i),
        .win_i   (win),
        .sel_i   (duty_q[FINE_W-1:0]),
        .hit_o   (hit)
    );

    dpwm_out_latch u_out (
        .clk    (clk_base_i),
        .rst_n  (rst_n_i),
        .wrap_i (wrap),
        .hit_i  (hit),
        .pwm_o  (pwm_o)
    );
endmodule

// File: rtl/seg_window_dpwm_chk.sv
// Property checker for the modulator, bound to the top module.
module seg_window_dpwm_chk #(
    parameter int CNT_W  = 2,
    parameter int DUTY_W = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic [CNT_W-1:0]  cnt,
    input logic [DUTY_W-1:0] duty_q,
    input logic              win,
    input logic              pwm
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
    localparam logic [CNT_W-1:0] CNT_ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    assert_count_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (cnt == $past(cnt) + CNT_ONE));

    assert_duty_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt != CNT_MAX) |=> $stable(duty_q));

    assert_slot_level_R5: assert property (@(posedge clk) disable iff (!rst_n)
        pwm == (cnt < duty_q[DUTY_W-1 -: CNT_W]));

    assert_window_slot_R5: assert property (@(posedge clk) disable iff (!rst_n)
        win |-> (cnt == duty_q[DUTY_W-1 -: CNT_W]));

    assert_single_window_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (win && cnt != CNT_MAX) |=> !win);
endmodule

bind seg_window_dpwm seg_window_dpwm_chk #(.CNT_W(CNT_W), .DUTY_W(DUTY_W)) u_chk (
    .clk    (clk_base_i),
    .rst_n  (rst_n_i),
    .cnt    (cnt),
    .duty_q (duty_q),
    .win    (win),
    .pwm    (pwm_o)
);

// File: tb/sim_seg_window_dpwm.sv
`timescale 1ps/1ps
module sim_seg_window_dpwm;
    localparam int STEP = 625;          // one sixteenth of the 10 ns base period
    localparam int TB   = 16 * STEP;    // base period, 100 MHz
    localparam int TP   = 4 * TB;       // switching period
    localparam int NV   = 11;
    localparam int VEC_D [NV] = '{27, 0, 63, 1, 16, 15, 48, 0, 32, 47, 5};
    localparam int VEC_H [NV] = '{27, 0, 63, 1, 16, 15, 48, 0, 32, 47, 5};

    logic       clk_base;
    logic       rst_n;
    logic [3:0] ph;
    logic       clk2x;
    logic [3:0] qtap;
    logic [5:0] duty;
    logic       pwm;
    int         n_chk  = 0;
    int         n_fail = 0;
    bit         done   = 0;

    seg_window_dpwm u0 (
        .clk_base_i (clk_base),
        .rst_n_i    (rst_n),
        .ph_i       (ph),
        .clk2x_i    (clk2x),
        .qtap_i     (qtap),
        .duty_i     (duty),
        .pwm_o      (pwm)
    );

    // Tap generator on a 0.625 ns step grid; all taps share the base-clock source.
    initial begin
        int p;
        p = 0;
        forever begin
            clk_base = (p < 8);
            for (int k = 0; k < 4; k++) ph[k] = (((p - 4 * k + 16) % 16) < 8);
            clk2x = ((p % 8) < 4);
            for (int j = 0; j < 4; j++) qtap[j] = ((p % 4) == j);
            #STEP;
            p = (p + 1) % 16;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic report;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    // Sample the 64 step centres of the period starting at t0; load nxt at step chg.
    task automatic measure(input longint t0, input int chg, input logic [5:0] nxt,
                           output int hi, output int first_low);
        hi = 0;
        first_low = -1;
        for (int n = 0; n < 64; n++) begin
            #(t0 + n * STEP + STEP / 2 - $time);
            if (pwm) hi++;
            else if (first_low < 0) first_low = n;
            if (n == chg) duty = nxt;
        end
        if (first_low < 0) first_low = 64;
    endtask

    initial begin
        #5_000_000;
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            report();
        end
    end

    initial begin
        longint t0;
        int     hi;
        int     fl;
        rst_n = 1'b0;
        duty  = 6'(VEC_D[0]);
        #(25_312);
        check(pwm == 1'b0, "R1 reset output", int'(pwm), 0);
        #(37_500 - $time);
        rst_n = 1'b1;

        // Table walk: each command gives the next one at mid-period (R4).
        t0 = 40_000;
        for (int i = 0; i < NV; i++) begin
            measure(t0, 32, 6'(VEC_D[(i + 1) % NV]), hi, fl);
            check(hi == VEC_H[i], "R8 high steps", hi, VEC_H[i]);
            check(fl == VEC_H[i], "R3 single interval from start", fl, VEC_H[i]);
            if (VEC_D[i] == 27) begin
                check(fl / 16 == 1, "R9 slot", fl / 16, 1);
                check((fl % 16) / 4 == 2, "R9 R6 quarter", (fl % 16) / 4, 2);
                check(fl % 4 == 3, "R9 R7 sixteenth", fl % 4, 3);
            end
            if (VEC_D[i] == 0) check(hi == 0, "R10 R11 zero command", hi, 0);
            if (VEC_D[i] == 63) check(fl == 63, "R10 full scale last step low", fl, 63);
            if (VEC_D[i] == 16) check(fl == 16, "R2 one slot per base cycle", fl, 16);
            if (VEC_D[i] == 32) check(hi == 32, "R5 earlier slot taps masked", hi, 32);
            t0 += TP;
        end

        // Directed R4: an early change in the period is ignored; the next period uses it.
        measure(t0, 63, 6'd40, hi, fl);
        t0 += TP;
        measure(t0, 2, 6'd10, hi, fl);
        check(hi == 40, "R4 early change ignored", hi, 40);
        t0 += TP;
        measure(t0, 63, 6'd51, hi, fl);
        check(hi == 10, "R4 change applied next period", hi, 10);
        t0 += TP;
        measure(t0, 63, 6'd60, hi, fl);
        check(hi == 51, "R5 R7 slot 3 quarter 0 tap 3", hi, 51);
        t0 += TP;

        // Directed R1: reset while the output is high forces it low; restart on release.
        #(t0 + 5_312 - $time);
        check(pwm == 1'b1, "R1 high before reset", int'(pwm), 1);
        rst_n = 1'b0;
        duty  = 6'd21;
        #200;
        check(pwm == 1'b0, "R1 low during reset", int'(pwm), 0);
        #(t0 + 27_500 - $time);
        rst_n = 1'b1;
        t0 += 30_000;
        measure(t0, 63, 6'd21, hi, fl);
        check(hi == 21, "R1 first period after release", hi, 21);
        check(fl == 21, "R3 interval after release", fl, 21);

        done = 1;
        report();
    end
endmodule